// File: doc/BRIEF.md
# Warp Fetch Arbiter with Per-Warp Instruction Buffers

This block sits in front of a shared instruction-cache port inside a multithreaded SIMD core. Every cycle it picks at most one warp and presents that warp's program counter to the cache. The cache answers in the same cycle with hit or miss. On a hit the returned word goes into the granted warp's small instruction buffer and the warp's PC moves to the next word. On a miss nothing is stored and the PC stays put, so the same address is asked for again when that warp next wins. The port never stalls on a miss.

Each warp owns a shallow in-order buffer. The downstream issue stage reads the buffer through flat valid, ready and instruction vectors. It removes the oldest entry with a per-warp pop. Hazard checking outside the block can mask the ready bits of a warp's entries, and can later unmask them. A warp competes for the port only while it is marked active, has not been retired by a done notice, and has at least one empty buffer slot. A branch redirect replaces a warp's PC and discards that warp's buffered entries.

Top module: `warp_fetch_arb`

## Requirements
- R1: At most one fetch request leaves the block per cycle. `fetch_req_o` is high exactly when some warp is eligible, and `fetch_pc_o` is the current PC of the warp named on `fetch_wid_o`.
- R2: A warp is eligible only when three conditions hold: its `warp_active_i` bit is high, it has not been retired, and its buffer holds fewer than IBUF_DEPTH valid entries.
- R3: The grant goes to the first eligible warp in ascending index order, wrapping around, starting just after the most recently granted warp. Both hits and misses count as grants. After reset the search starts at warp 0.
- R4: On a hit the word on `fetch_instr_i` is written into the lowest free slot of the granted warp, with its valid and ready bits set, and the warp's PC increases by one. The effect is visible the following cycle. Slot 0 is always the oldest entry. Status bit (w, s) is at index w*IBUF_DEPTH+s, and instruction field (w, s) is at bits [(w*IBUF_DEPTH+s)*INSTR_W +: INSTR_W].
- R5: On a miss nothing is written and the PC is unchanged. The next grant of that warp requests the same PC.
- R6: `pop_i[w]` removes warp w's slot-0 entry and moves the younger entries down by one. The freed slot shows as invalid on the next cycle, and from that cycle the warp may compete again. A pop on an empty buffer changes nothing.
- R7: `hazard_i[w]` clears the ready bits of all entries of warp w that remain valid. `release_i[w]` sets them, and hazard wins when both are high. An entry written in the same cycle is ready, and invalid slots always read not-ready.
- R8: `branch_valid_i` replaces the PC of warp `branch_wid_i` with `branch_pc_i` and invalidates all of that warp's entries. A hit for that warp in the same cycle is discarded.
- R9: `done_valid_i` retires warp `done_wid_i`. From the next cycle until reset, that warp is never granted.
- R10: Reset invalidates every entry, clears every ready bit, un-retires all warps, and loads each warp's PC with BASE_PC + w*PC_STRIDE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_active_i | input | NUM_WARPS | Per-warp resident/valid flag |
| done_valid_i | input | 1 | Retire notice strobe |
| done_wid_i | input | WID_W | Warp being retired |
| fetch_req_o | output | 1 | Cache lookup request |
| fetch_wid_o | output | WID_W | Granted warp |
| fetch_pc_o | output | PC_W | PC presented to the cache |
| fetch_hit_i | input | 1 | Same-cycle cache hit |
| fetch_instr_i | input | INSTR_W | Tagged instruction word returned on a hit |
| branch_valid_i | input | 1 | Redirect strobe |
| branch_wid_i | input | WID_W | Warp being redirected |
| branch_pc_i | input | PC_W | Redirect target |
| pop_i | input | NUM_WARPS | Per-warp removal of the oldest entry |
| hazard_i | input | NUM_WARPS | Per-warp ready mask request |
| release_i | input | NUM_WARPS | Per-warp ready unmask request |
| ibuf_valid_o | output | NUM_WARPS*IBUF_DEPTH | Entry valid bits |
| ibuf_ready_o | output | NUM_WARPS*IBUF_DEPTH | Entry ready bits |
| ibuf_instr_o | output | NUM_WARPS*IBUF_DEPTH*INSTR_W | Entry instruction words |

## Verification
The bench first runs a fill sweep with every warp active and every lookup hitting. In that sweep each warp should be granted twice in strict rotation, and the port should then go quiet. This separates correct rotation and full-buffer gating from a fixed-priority grant or an off-by-one in the room test.

Directed phases then cover four cases:
- a single-warp pop, which shows that eligibility returns one cycle after the pop;
- a forced miss, which shows the PC is held;
- a redirect that lands in the same cycle as that warp's hit;
- hazard and release applied together.

A long pseudo-random phase mixes misses, pops, redirects and ready masking, and compares against a bench model built from the requirements. A final retirement phase confirms that retired warps drop out of the rotation while the rest keep fetching.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

    // What happens to one warp in one cycle, from the fetch side
    typedef enum logic [1:0] {
        EV_NONE     = 2'd0,
        EV_HIT      = 2'd1,
        EV_MISS     = 2'd2,
        EV_REDIRECT = 2'd3
    } fetch_evt_e;

endpackage

// File: rtl/wfa_rr_picker.sv
module wfa_rr_picker #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic          gnt_valid_o,
    output logic [IW-1:0] gnt_idx_o
);

    typedef struct packed {
        logic [IW-1:0] last;
    } pick_st_t;

    pick_st_t      s_d, s_q;
    logic [IW-1:0] cand;

    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_idx_o   = '0;
        cand        = '0;
        for (int k = 1; k <= N; k++) begin
            cand = IW'((int'(s_q.last) + k) % N);
            if (!gnt_valid_o && req_i[cand]) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = cand;
            end
        end
        s_d = s_q;
        if (gnt_valid_o) s_d.last = gnt_idx_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.last <= IW'(N - 1);
        else        s_q      <= s_d;
    end

endmodule

// File: rtl/wfa_warp_pc.sv
module wfa_warp_pc #(
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect_i,
    input  logic [PC_W-1:0] target_i,
    input  logic            advance_i,
    output logic [PC_W-1:0] pc_o
);

    logic [PC_W-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (redirect_i)     pc_d = target_i;
        else if (advance_i) pc_d = pc_q + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/wfa_warp_ibuf.sv
module wfa_warp_ibuf #(
    parameter int DEPTH = 2,
    parameter int DW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic                      push_i,
    input  logic [DW-1:0]             push_data_i,
    input  logic                      pop_i,
    input  logic                      hazard_i,
    input  logic                      release_i,
    output logic [DEPTH-1:0]          valid_o,
    output logic [DEPTH-1:0]          ready_o,
    output logic [DEPTH-1:0][DW-1:0]  data_o,
    output logic                      room_o
);

    typedef struct packed {
        logic [CW-1:0]             cnt;
        logic [DEPTH-1:0]          rdy;
        logic [DEPTH-1:0][DW-1:0]  ent;
    } ibuf_st_t;

    ibuf_st_t      s_d, s_q;
    logic [CW-1:0] wr_slot;

    always_comb begin
        s_d     = s_q;
        wr_slot = '0;
        if (flush_i) begin
            s_d.cnt = '0;
            s_d.rdy = '0;
        end else begin
            // oldest entry leaves, younger ones slide toward slot 0
            if (pop_i && s_q.cnt != '0) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    s_d.ent[i] = s_q.ent[i+1];
                    s_d.rdy[i] = s_q.rdy[i+1];
                end
                s_d.rdy[DEPTH-1] = 1'b0;
                s_d.cnt          = s_q.cnt - CW'(1);
            end
            // ready masking acts on entries that survive the pop
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) < s_d.cnt) begin
                    if (hazard_i)       s_d.rdy[i] = 1'b0;
                    else if (release_i) s_d.rdy[i] = 1'b1;
                end
            end
            wr_slot = s_d.cnt;
            if (push_i && wr_slot < CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == wr_slot) begin
                        s_d.ent[i] = push_data_i;
                        s_d.rdy[i] = 1'b1;
                    end
                end
                s_d.cnt = wr_slot + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) valid_o[i] = CW'(i) < s_q.cnt;
    end
    assign ready_o = s_q.rdy;
    assign data_o  = s_q.ent;
    assign room_o  = s_q.cnt < CW'(DEPTH);

endmodule

// File: rtl/warp_fetch_arb.sv
module warp_fetch_arb
    import wfa_pkg::*;
#(
    parameter int              NUM_WARPS  = 8,
    parameter int              IBUF_DEPTH = 2,
    parameter int              PC_W       = 16,
    parameter int              INSTR_W    = 32,
    parameter int              WID_W      = $clog2(NUM_WARPS),
    parameter logic [PC_W-1:0] BASE_PC    = 16'h0100,
    parameter logic [PC_W-1:0] PC_STRIDE  = 16'h0040
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic [NUM_WARPS-1:0]                            warp_active_i,
    input  logic                                            done_valid_i,
    input  logic [WID_W-1:0]                                done_wid_i,
    output logic                                            fetch_req_o,
    output logic [WID_W-1:0]                                fetch_wid_o,
    output logic [PC_W-1:0]                                 fetch_pc_o,
    input  logic                                            fetch_hit_i,
    input  logic [INSTR_W-1:0]                              fetch_instr_i,
    input  logic                                            branch_valid_i,
    input  logic [WID_W-1:0]                                branch_wid_i,
    input  logic [PC_W-1:0]                                 branch_pc_i,
    input  logic [NUM_WARPS-1:0]                            pop_i,
    input  logic [NUM_WARPS-1:0]                            hazard_i,
    input  logic [NUM_WARPS-1:0]                            release_i,
    output logic [NUM_WARPS-1:0][IBUF_DEPTH-1:0]            ibuf_valid_o,
    output logic [NUM_WARPS-1:0][IBUF_DEPTH-1:0]            ibuf_ready_o,
    output logic [NUM_WARPS-1:0][IBUF_DEPTH-1:0][INSTR_W-1:0] ibuf_instr_o
);

    typedef struct packed {
        logic [NUM_WARPS-1:0] retired;
    } top_st_t;

    top_st_t                         s_d, s_q;
    logic [NUM_WARPS-1:0]            retired_q;
    logic [NUM_WARPS-1:0]            room;
    logic [NUM_WARPS-1:0]            elig;
    logic [NUM_WARPS-1:0][PC_W-1:0]  pc_all;
    logic                            gnt_valid;
    logic [WID_W-1:0]                gnt_idx;

    // retirement bookkeeping
    always_comb begin
        s_d = s_q;
        if (done_valid_i) s_d.retired[done_wid_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign retired_q = s_q.retired;
    assign elig      = warp_active_i & ~retired_q & room;

    wfa_rr_picker #(
        .N  (NUM_WARPS),
        .IW (WID_W)
    ) u_picker (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (elig),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_idx)
    );

    assign fetch_req_o = gnt_valid;
    assign fetch_wid_o = gnt_idx;
    assign fetch_pc_o  = pc_all[gnt_idx];

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        fetch_evt_e evt;
        logic       redirect;

        always_comb begin
            redirect = branch_valid_i && (branch_wid_i == WID_W'(w));
            if (redirect)
                evt = EV_REDIRECT;
            else if (gnt_valid && gnt_idx == WID_W'(w))
                evt = fetch_hit_i ? EV_HIT : EV_MISS;
            else
                evt = EV_NONE;
        end

        wfa_warp_pc #(
            .PC_W     (PC_W),
            .RESET_PC (BASE_PC + PC_W'(w) * PC_STRIDE)
        ) u_pc (
            .clk        (clk),
            .rst_n      (rst_n),
            .redirect_i (evt == EV_REDIRECT),
            .target_i   (branch_pc_i),
            .advance_i  (evt == EV_HIT),
            .pc_o       (pc_all[w])
        );

        wfa_warp_ibuf #(
            .DEPTH (IBUF_DEPTH),
            .DW    (INSTR_W)
        ) u_ibuf (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (evt == EV_REDIRECT),
            .push_i      (evt == EV_HIT),
            .push_data_i (fetch_instr_i),
            .pop_i       (pop_i[w]),
            .hazard_i    (hazard_i[w]),
            .release_i   (release_i[w]),
            .valid_o     (ibuf_valid_o[w]),
            .ready_o     (ibuf_ready_o[w]),
            .data_o      (ibuf_instr_o[w]),
            .room_o      (room[w])
        );
    end

endmodule

// File: rtl/wfa_checker.sv
module wfa_checker #(
    parameter int NUM_WARPS  = 8,
    parameter int IBUF_DEPTH = 2,
    parameter int WID_W      = 3
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [NUM_WARPS-1:0]                 warp_active_i,
    input logic                                 fetch_req_o,
    input logic [WID_W-1:0]                     fetch_wid_o,
    input logic                                 fetch_hit_i,
    input logic                                 branch_valid_i,
    input logic [WID_W-1:0]                     branch_wid_i,
    input logic [NUM_WARPS-1:0]                 pop_i,
    input logic [NUM_WARPS-1:0]                 retired_q,
    input logic [NUM_WARPS-1:0][IBUF_DEPTH-1:0] ibuf_valid_o,
    input logic [NUM_WARPS-1:0][IBUF_DEPTH-1:0] ibuf_ready_o
);

    p_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> !ibuf_valid_o[fetch_wid_o][IBUF_DEPTH-1]);

    p_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> warp_active_i[fetch_wid_o]);

    p_retired_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> !retired_q[fetch_wid_o]);

    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid_i |=> ibuf_valid_o[$past(branch_wid_i)] == '0);

    p_miss_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fetch_hit_i && !pop_i[fetch_wid_o]
         && !(branch_valid_i && branch_wid_i == fetch_wid_o))
        |=> ibuf_valid_o[$past(fetch_wid_o)] == $past(ibuf_valid_o[fetch_wid_o]));

    p_ready_on_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ibuf_ready_o & ~ibuf_valid_o) == '0);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
        for (genvar s = 0; s < IBUF_DEPTH - 1; s++) begin : g_s
            p_packed_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ibuf_valid_o[w][s+1] |-> ibuf_valid_o[w][s]);
        end
    end

endmodule

bind warp_fetch_arb wfa_checker #(
    .NUM_WARPS  (NUM_WARPS),
    .IBUF_DEPTH (IBUF_DEPTH),
    .WID_W      (WID_W)
) u_wfa_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .warp_active_i  (warp_active_i),
    .fetch_req_o    (fetch_req_o),
    .fetch_wid_o    (fetch_wid_o),
    .fetch_hit_i    (fetch_hit_i),
    .branch_valid_i (branch_valid_i),
    .branch_wid_i   (branch_wid_i),
    .pop_i          (pop_i),
    .retired_q      (retired_q),
    .ibuf_valid_o   (ibuf_valid_o),
    .ibuf_ready_o   (ibuf_ready_o)
);

// File: tb/tb_warp_fetch_arb.sv
`timescale 1ns/1ps
module tb_warp_fetch_arb;

    localparam int N  = 8;
    localparam int D  = 2;
    localparam int PW = 16;
    localparam int IW = 32;
    localparam int WW = 3;
    localparam logic [PW-1:0] BASE   = 16'h0100;
    localparam logic [PW-1:0] STRIDE = 16'h0040;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]          warp_active_i = '0;
    logic                  done_valid_i = 1'b0;
    logic [WW-1:0]         done_wid_i = '0;
    logic                  fetch_req_o;
    logic [WW-1:0]         fetch_wid_o;
    logic [PW-1:0]         fetch_pc_o;
    logic                  fetch_hit_i = 1'b0;
    logic [IW-1:0]         fetch_instr_i = '0;
    logic                  branch_valid_i = 1'b0;
    logic [WW-1:0]         branch_wid_i = '0;
    logic [PW-1:0]         branch_pc_i = '0;
    logic [N-1:0]          pop_i = '0;
    logic [N-1:0]          hazard_i = '0;
    logic [N-1:0]          release_i = '0;
    logic [N-1:0][D-1:0]   ibuf_valid_o;
    logic [N-1:0][D-1:0]   ibuf_ready_o;
    logic [N-1:0][D-1:0][IW-1:0] ibuf_instr_o;

    warp_fetch_arb #(
        .NUM_WARPS(N), .IBUF_DEPTH(D), .PC_W(PW), .INSTR_W(IW),
        .WID_W(WW), .BASE_PC(BASE), .PC_STRIDE(STRIDE)
    ) dut (.*);

    // bench-side model built from the requirements
    int             n_checks = 0;
    int             n_errors = 0;
    bit             finished = 0;
    logic [PW-1:0]  m_pc  [N];
    int             m_cnt [N];
    logic [IW-1:0]  m_ins [N][D];
    bit             m_rdy [N][D];
    bit             m_done[N];
    int             m_last;
    logic [N-1:0]   miss_mask = '0;
    logic [31:0]    lf = 32'h1ACE_B00C;

    function automatic logic [IW-1:0] mk_instr(int w, logic [PW-1:0] pc);
        return {4'hC, 4'(w), 8'h5A, pc};
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < N; w++) begin
            m_pc[w]   = BASE + PW'(w) * STRIDE;
            m_cnt[w]  = 0;
            m_done[w] = 0;
            for (int s = 0; s < D; s++) m_rdy[w][s] = 0;
        end
        m_last = N - 1;
    endtask

    function automatic int pick();
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (m_last + k) % N;
            if (warp_active_i[c] && !m_done[c] && m_cnt[c] < D) return c;
        end
        return -1;
    endfunction

    task automatic compare_bufs();
        for (int w = 0; w < N; w++) begin
            for (int s = 0; s < D; s++) begin
                check("R6", $sformatf("valid w%0d s%0d", w, s), ibuf_valid_o[w][s], s < m_cnt[w]);
                check("R7", $sformatf("ready w%0d s%0d", w, s), ibuf_ready_o[w][s],
                      (s < m_cnt[w]) ? m_rdy[w][s] : 0);
                if (s < m_cnt[w])
                    check("R4", $sformatf("instr w%0d s%0d", w, s), ibuf_instr_o[w][s], m_ins[w][s]);
            end
        end
    endtask

    // One clock: called just after a falling edge with inputs set.
    task automatic cyc();
        int  g;
        bit  hit;
        #1;
        g = pick();
        check("R1", "fetch_req", fetch_req_o, g >= 0);
        hit = 0;
        if (g >= 0) begin
            check("R3", "fetch_wid", fetch_wid_o, g);
            check("R5", "fetch_pc", fetch_pc_o, m_pc[g]);
            hit = !miss_mask[g];
            fetch_hit_i   = hit;
            fetch_instr_i = mk_instr(g, m_pc[g]);
        end else begin
            fetch_hit_i = 1'b0;
        end
        @(posedge clk);
        for (int w = 0; w < N; w++) begin
            if (branch_valid_i && branch_wid_i == WW'(w)) begin
                m_cnt[w] = 0;
                m_pc[w]  = branch_pc_i;
                for (int s = 0; s < D; s++) m_rdy[w][s] = 0;
            end else begin
                if (pop_i[w] && m_cnt[w] > 0) begin
                    for (int s = 0; s < D - 1; s++) begin
                        m_ins[w][s] = m_ins[w][s+1];
                        m_rdy[w][s] = m_rdy[w][s+1];
                    end
                    m_rdy[w][D-1] = 0;
                    m_cnt[w]--;
                end
                for (int s = 0; s < m_cnt[w]; s++) begin
                    if (hazard_i[w])       m_rdy[w][s] = 0;
                    else if (release_i[w]) m_rdy[w][s] = 1;
                end
                if (g == w && hit) begin
                    m_ins[w][m_cnt[w]] = mk_instr(w, m_pc[w]);
                    m_rdy[w][m_cnt[w]] = 1;
                    m_cnt[w]++;
                    m_pc[w] = m_pc[w] + 1'b1;
                end
            end
        end
        if (done_valid_i) m_done[done_wid_i] = 1;
        if (g >= 0) m_last = g;
        @(negedge clk);
        done_valid_i   = 1'b0;
        branch_valid_i = 1'b0;
        pop_i          = '0;
        hazard_i       = '0;
        release_i      = '0;
        fetch_hit_i    = 1'b0;
        compare_bufs();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state seen at the ports
        check("R10", "valid after reset", ibuf_valid_o, 0);
        check("R10", "ready after reset", ibuf_ready_o, 0);
        #1;
        check("R1", "no request with no active warp", fetch_req_o, 0);
        warp_active_i = '1;
        #1;
        check("R10", "first grant warp", fetch_wid_o, 0);
        check("R10", "first grant pc", fetch_pc_o, BASE);
        warp_active_i = '0;
        @(negedge clk);

        // R3/R4 fill sweep: all hit, two rotations, then the port idles
        warp_active_i = '1;
        for (int i = 0; i < 2 * N + 2; i++) cyc();
        check("R2", "idle when all buffers full", fetch_req_o, 0);
        check("R4", "warp5 slot1 word", ibuf_instr_o[5][1], mk_instr(5, BASE + 5 * STRIDE + 1));
        check("R4", "warp0 slot0 word", ibuf_instr_o[0][0], mk_instr(0, BASE));

        // R6: pop warp 3, it refetches only the cycle after the pop
        pop_i[3] = 1'b1;
        #1;
        check("R6", "no request in pop cycle", fetch_req_o, 0);
        cyc();
        check("R6", "warp3 shifted head", ibuf_instr_o[3][0], mk_instr(3, BASE + 3 * STRIDE + 1));
        cyc();

        // R5: miss on warp 3 holds its PC
        pop_i[3] = 1'b1;
        cyc();
        miss_mask[3] = 1'b1;
        cyc();
        cyc();
        miss_mask = '0;
        cyc();
        check("R5", "warp3 refetch after miss", ibuf_instr_o[3][1], mk_instr(3, BASE + 3 * STRIDE + 3));

        // R7: hazard masks, release unmasks, hazard wins when both
        hazard_i[2] = 1'b1;
        cyc();
        check("R7", "masked ready w2", ibuf_ready_o[2], 0);
        hazard_i[2] = 1'b1; release_i[2] = 1'b1;
        cyc();
        release_i[2] = 1'b1;
        cyc();
        check("R7", "unmasked ready w2", ibuf_ready_o[2], 2'b11);

        // R8: redirect warp 6 while it hits in the same cycle
        pop_i = '1;
        cyc();
        pop_i = '1;
        cyc();
        for (int i = 0; i < N; i++) begin
            #1;
            if (fetch_req_o && fetch_wid_o == 3'd6) begin
                branch_valid_i = 1'b1; branch_wid_i = 3'd6; branch_pc_i = 16'h7700;
            end
            cyc();
        end
        check("R8", "redirected warp pc loaded", m_pc[6] >= 16'h7700, 1);
        // R6: pop on empty warp after a flush changes nothing
        branch_valid_i = 1'b1; branch_wid_i = 3'd1; branch_pc_i = 16'h0EE0;
        warp_active_i[1] = 1'b0;
        cyc();
        pop_i[1] = 1'b1;
        cyc();
        check("R6", "empty pop ignored", ibuf_valid_o[1], 0);
        warp_active_i = '1;

        // mixed pseudo-random sweep against the model
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            warp_active_i = lf[7:0] | 8'h81;
            pop_i         = lf[15:8];
            miss_mask     = lf[23:16] & lf[31:24];
            hazard_i      = (lf[3:0] == 4'h5) ? lf[15:8] : '0;
            release_i     = (lf[5:2] == 4'h9) ? lf[23:16] : '0;
            if (lf[30:28] == 3'd0) begin
                branch_valid_i = 1'b1;
                branch_wid_i   = lf[11:9];
                branch_pc_i    = {lf[27:20], 8'h00};
            end
            cyc();
        end
        miss_mask = '0;

        // R9: retire warps 0 and 4, then they never fetch again
        done_valid_i = 1'b1; done_wid_i = 3'd0;
        cyc();
        done_valid_i = 1'b1; done_wid_i = 3'd4;
        cyc();
        warp_active_i = '1;
        for (int i = 0; i < 40; i++) begin
            pop_i = '1;
            #1;
            if (fetch_req_o)
                check("R9", "retired warp not granted",
                      (fetch_wid_o == 3'd0) || (fetch_wid_o == 3'd4), 0);
            cyc();
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule